// File: doc/BRIEF.md
# Masked Priority Interrupt Vectorer

This block gathers a set of level-sensitive interrupt request lines from local-bus peripherals into a source register, qualifies them with a software-programmable enable mask, and drives a single combined interrupt line towards the processor. A request bit is pending when its line is high and its enable bit is set. While any bit is pending, the combined output stays high.

Software reaches the block through a small 16-bit register port that accepts byte enables. One register returns an encoded vector that names the lowest-numbered pending request. A second register holds the enable mask, which software can read and write. Byte writes change only the selected lane of the mask. Edge capture, nesting and acknowledge handshakes are not part of this block. The interrupt handler reads the vector, services that peripheral, and the request clears once the peripheral drops its line.

Top module: `irq_vectorer`

## Requirements
- R1: On every clock edge the source register loads the current level of each request line, so a bit is set while its line is high and is clear while its line is low.
- R2: `irq_o` is high in the cycle after an edge at which (source AND mask) is nonzero, and is low in the cycle after an edge at which it is zero.
- R3: A read with word index 0 (byte offsets 0 and 1) returns (i+1)*4, where i is the lowest-numbered pending bit. It returns 0 when no bit is pending. The value is combinational from the registered source and mask.
- R4: A read with word index 1 (byte offsets 2 and 3) returns the mask. Mask bits at or above NUM_SRC read as 0.
- R5: A write with word index 1 updates the mask at that clock edge. `irq_o` follows the new pending set one edge later.
- R6: Byte enable bit 0 selects mask bits 7:0 and byte enable bit 1 selects mask bits 15:8. A lane whose enable is low keeps its current value.
- R7: After reset the mask is 0x0010, the source register is 0 and `irq_o` is 0.
- R8: Writes with word index 0 leave the mask unchanged. Reads with word index 2 or above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Level-sensitive request lines |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_i | input | 1 | Write strobe for this cycle |
| be_i | input | 2 | Byte lane enables for the write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Combined registered interrupt output |

## Verification
The assertions assume that every input is synchronous to `clk` and carries known values once reset is released. The temporal checks only start one cycle after reset, once the source register has taken a real sample. The stimulus drives all requests and bus inputs one time unit after the rising edge and holds them for the whole cycle. Each write strobe lasts exactly one cycle, so every edge sees stable, known values.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int DATA_W   = 16;
   localparam int LANE_W   = 8;
   localparam int NUM_LANE = DATA_W / LANE_W;
   localparam int VEC_SH   = 2;

   typedef enum logic [1:0] {
      WSEL_VEC  = 2'd0,
      WSEL_MASK = 2'd1,
      WSEL_NONE = 2'd2
   } wsel_e;
endpackage

// File: rtl/irqv_src_reg.sv
module irqv_src_reg #(
   parameter int NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   output logic [NUM_SRC-1:0] src_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_o <= '0;
      else        src_o <= req_i;
   end
endmodule

// File: rtl/irqv_mask_reg.sv
module irqv_mask_reg
   import irqv_pkg::*;
#(
   parameter int          NUM_SRC  = 16,
   parameter logic [15:0] MASK_RST = 16'h0010
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [NUM_LANE-1:0] be_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   mask_o
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int LANE = b / LANE_W;
      if (b < NUM_SRC) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      mask_o[b] <= MASK_RST[b];
            else if (wr_en_i && be_i[LANE])  mask_o[b] <= wdata_i[b];
         end
      end else begin : g_pad
         assign mask_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
   import irqv_pkg::*;
#(
   parameter int NUM_SRC = 16
) (
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [DATA_W-1:0]  code_o
);
   always_comb begin
      code_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend_i[i]) code_o = DATA_W'((i + 1) << VEC_SH);
      end
   end
endmodule

// File: rtl/irq_vectorer.sv
module irq_vectorer
   import irqv_pkg::*;
#(
   parameter int          NUM_SRC  = 16,
   parameter int          ADDR_W   = 4,
   parameter logic [15:0] MASK_RST = 16'h0010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_i,
   input  logic [1:0]         be_i,
   input  logic [15:0]        wdata_i,
   output logic [15:0]        rdata_o,
   output logic               irq_o
);
   localparam int WORD_W = ADDR_W - 1;

   initial begin
      if (NUM_SRC < 1 || NUM_SRC > DATA_W)
         $error("irq_vectorer: NUM_SRC must lie in 1..%0d", DATA_W);
      if (ADDR_W < 3)
         $error("irq_vectorer: ADDR_W must be at least 3");
   end

   logic [WORD_W-1:0]  word;
   wsel_e              wsel;
   logic [NUM_SRC-1:0] src_q;
   logic [DATA_W-1:0]  mask_q;
   logic [NUM_SRC-1:0] pend;
   logic [DATA_W-1:0]  vec_code;
   logic               irq_q;

   assign word = addr_i[ADDR_W-1:1];

   always_comb begin
      if (word == WORD_W'(0))      wsel = WSEL_VEC;
      else if (word == WORD_W'(1)) wsel = WSEL_MASK;
      else                         wsel = WSEL_NONE;
   end

   irqv_src_reg #(.NUM_SRC(NUM_SRC)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_i),
      .src_o (src_q)
   );

   irqv_mask_reg #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_i && (wsel == WSEL_MASK)),
      .be_i    (be_i),
      .wdata_i (wdata_i),
      .mask_o  (mask_q)
   );

   assign pend = src_q & mask_q[NUM_SRC-1:0];

   irqv_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
      .pend_i (pend),
      .code_o (vec_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend;
   end

   always_comb begin
      unique case (wsel)
         WSEL_VEC:  rdata_o = vec_code;
         WSEL_MASK: rdata_o = mask_q;
         default:   rdata_o = '0;
      endcase
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
   parameter int NUM_SRC = 16,
   parameter int ADDR_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] req_i,
   input logic [ADDR_W-1:0]  addr_i,
   input logic               wr_i,
   input logic [1:0]         be_i,
   input logic [15:0]        rdata_o,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] src_q,
   input logic [15:0]        mask_q
);
   logic armed;
   logic [ADDR_W-2:0] wd;
   logic [NUM_SRC-1:0] pd;

   assign wd = addr_i[ADDR_W-1:1];
   assign pd = src_q & mask_q[NUM_SRC-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_src_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> src_q == $past(req_i));
   p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pd != '0) |=> irq_o);
   p_irq_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pd == '0) |=> !irq_o);
   p_vec_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wd == '0) |-> (rdata_o[1:0] == 2'b00 && rdata_o <= 16'(NUM_SRC * 4)));
   p_vec_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wd == '0 && pd == '0) |-> rdata_o == 16'h0);
   p_mask_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wd == (ADDR_W-1)'(1)) |-> rdata_o == mask_q);
   p_lane_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_i && wd == (ADDR_W-1)'(1) && !be_i[1]) |=> mask_q[15:8] == $past(mask_q[15:8]));
   p_vec_wr_ign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_i && wd == '0) |=> $stable(mask_q));
   p_unk_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wd > (ADDR_W-1)'(1)) |-> rdata_o == 16'h0);
endmodule

bind irq_vectorer irqv_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_i   (req_i),
   .addr_i  (addr_i),
   .wr_i    (wr_i),
   .be_i    (be_i),
   .rdata_o (rdata_o),
   .irq_o   (irq_o),
   .src_q   (src_q),
   .mask_q  (mask_q)
);

// File: tb/irq_vectorer_tb.sv
`timescale 1ns/1ps
module irq_vectorer_tb;
   localparam int NSRC = 16;
   localparam int AW   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] req = '0;
   logic [AW-1:0]   addr = '0;
   logic            wr = 1'b0;
   logic [1:0]      be = 2'b00;
   logic [15:0]     wdata = '0;
   logic [15:0]     rdata;
   logic            irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [15:0] src_m;
   logic [15:0] mask_m;
   logic        irq_m;

   always #2.5 clk = ~clk;

   irq_vectorer #(.NUM_SRC(NSRC), .ADDR_W(AW), .MASK_RST(16'h0010)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .wr_i(wr),
      .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   function automatic logic [15:0] exp_vec(logic [15:0] p);
      for (int i = 0; i < NSRC; i++)
         if (p[i]) return 16'((i + 1) * 4);
      return 16'h0;
   endfunction

   function automatic logic [15:0] exp_read(logic [AW-1:0] a);
      case (a >> 1)
         0:       return exp_vec(src_m & mask_m);
         1:       return mask_m;
         default: return 16'h0;
      endcase
   endfunction

   task automatic check(string req_tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
      end
   endtask

   // one clock: update model as the DUT does at the edge, then check irq
   task automatic tick();
      @(posedge clk);
      irq_m = |(src_m & mask_m);
      src_m = req;
      if (wr && (addr >> 1) == 1) begin
         if (be[0]) mask_m[7:0]  = wdata[7:0];
         if (be[1]) mask_m[15:8] = wdata[15:8];
      end
      #1;
      wr = 1'b0;
      check("R2 irq level", {15'h0, irq}, {15'h0, irq_m});
   endtask

   task automatic rd(string req_tag, logic [AW-1:0] a);
      addr = a;
      #0.5;
      check(req_tag, rdata, exp_read(a));
   endtask

   task automatic wrt(logic [AW-1:0] a, logic [1:0] b, logic [15:0] d);
      addr = a; be = b; wdata = d; wr = 1'b1;
      tick();
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] sd;
      sd = $urandom(32'h1d5);
      src_m = '0; mask_m = 16'h0010; irq_m = 1'b0;
      #12;
      // R7 reset state
      check("R7 irq at reset", {15'h0, irq}, 16'h0);
      rd("R7 mask reset", 4'd2);
      check("R7 mask value", rdata, 16'h0010);
      rd("R7 vector at reset", 4'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;

      // R1/R3 reset mask only passes bit 4
      req = 16'h0011; tick(); rd("R1 R3 masked low bit", 4'd0);
      check("R3 bit4 vector", rdata, 16'd20);
      tick();
      check("R2 irq after pending", {15'h0, irq}, 16'h1);

      // R5 R6 full mask via two byte writes
      wrt(4'd2, 2'b01, 16'hAAFF); rd("R6 low lane", 4'd2);
      check("R6 low lane only", rdata, 16'h00FF);
      wrt(4'd3, 2'b10, 16'hFF55); rd("R6 high lane", 4'd2);
      check("R6 merged", rdata, 16'hFFFF);
      rd("R3 lowest bit0", 4'd0);
      check("R3 bit0 vector", rdata, 16'd4);

      // R3 top bit
      req = 16'h8000; tick(); rd("R3 top bit", 4'd0);
      check("R3 bit15 vector", rdata, 16'd64);

      // R8 ignored write at word 0
      wrt(4'd0, 2'b11, 16'h0000); rd("R8 write ignored", 4'd2);
      check("R8 mask kept", rdata, 16'hFFFF);
      rd("R8 unknown 4", 4'd4);
      rd("R8 unknown 14", 4'd14);

      // R5 clear mask, irq drops one edge later
      wrt(4'd2, 2'b11, 16'h0000); tick();
      check("R5 irq low after mask clear", {15'h0, irq}, 16'h0);
      rd("R3 none pending", 4'd0);
      check("R3 idle vector", rdata, 16'h0);

      // R1 release lines
      wrt(4'd2, 2'b11, 16'hFFFF); req = '0; tick();
      rd("R1 lines low", 4'd0);

      // random phase
      for (int n = 0; n < 600; n++) begin
         req = 16'($urandom);
         if (($urandom % 3) == 0) begin
            addr = AW'($urandom); be = 2'($urandom); wdata = 16'($urandom);
            wr = 1'b1;
         end
         tick();
         rd("R3 R4 R8 random read", AW'($urandom));
         rd("R3 random vector", 4'd0);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule